// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a clocked host and an asynchronous static RAM of 512K words by 8 bits. The host issues one request at a time: a pulse on `req` with a write flag, an address and, for writes, a data byte. The controller latches the request, drops `ready`, and plays out the active-low chip-select, write-enable and output-enable strobes toward the memory. It also steers the direction of the shared data bus. Each phase of the strobe sequence lasts a parameterised number of clock cycles. The integrator chooses these counts by rounding the memory's nanosecond minimums up to whole periods of the clock in use. The defaults suit a 10 ns clock.

A write has three phases. First, address and data are presented with chip select low. Next, write enable is pulsed low. Finally, write enable rises while chip select, address and data remain valid for a hold phase. Only the write-enable edge ends the write, so data setup and hold are both measured from that one edge. A read has two phases. First, chip select and output enable are held low with write enable high, and the bus is sampled on the last cycle of that window. Then a turnaround phase keeps the controller's drivers off until the memory has floated its outputs. The captured byte comes back with a one-cycle valid pulse.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: A write pulls `memWeN` low for exactly WE_CYC consecutive cycles. `memCsN` is low and `memOeN` is high throughout, and the data drivers (`memDqOe`=1) are on.
- R2: For a write, `memCsN` falls and `memAddr`/`memDqOut` are valid SETUP_CYC cycles before `memWeN` falls. After `memWeN` rises, `memCsN` stays low and the address and data stay driven for HOLD_CYC more cycles, so write enable alone terminates the write. `memAddr` does not change while `memCsN` is low.
- R3: A read holds `memCsN` and `memOeN` low with `memWeN` high for exactly RD_CYC cycles. The address stays stable throughout.
- R4: `memDqOe` is never 1 while `memOeN` is low. It stays 0 for at least TURN_CYC full cycles after `memOeN` returns high, and it goes to 0 in the first cycle after the write hold phase ends.
- R5: The byte on `memDqIn` in the last cycle of the output-enable window appears on `rdData`. In the next cycle `rdValid` is high for exactly one cycle, and `rdData` holds its value until the next read.
- R6: `ready` is high only while no access is in progress. A `req` seen while `ready` is low is ignored and changes neither the memory nor the address in use.
- R7: After reset, `memCsN`, `memWeN` and `memOeN` are high, `memDqOe` is 0, `ready` is 1 and `rdValid` is 0.
- R8: A byte written to an address is returned by a later read of that address. This holds when a write follows a read back to back, and the reverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, taken when `ready` is high |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| ready | output | 1 | Controller idle and able to take a request |
| rdData | output | DATA_W | Last captured read byte |
| rdValid | output | 1 | One-cycle pulse when `rdData` is new |
| memAddr | output | ADDR_W | Address to memory |
| memCsN | output | 1 | Chip select, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memDqOut | output | DATA_W | Data toward memory |
| memDqOe | output | 1 | Enables the data drivers toward memory |
| memDqIn | input | DATA_W | Data from memory |

## Verification
The assertions check the strobe combinations on every cycle: write enable only under chip select, output enable never together with write enable, and no data drive during output enable or its float window. They also check that chip select and data remain valid in the cycle write enable rises, that the address stays stable while selected, and that the read-valid pulse lasts one cycle. Only the bench's scenarios can show the exact phase lengths against the configured cycle counts and the nanosecond minimums. The same holds for whether a dropped request really leaves memory untouched, and for whether data survives write/read round trips across the whole address space, including back-to-back turnarounds.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPUL,
    ST_WHLD,
    ST_RACT,
    ST_RTRN
  } ctrlState_e;

  typedef struct packed {
    logic csN;
    logic weN;
    logic oeN;
    logic drive;
    logic capture;
    logic accept;
    logic idle;
  } strobe_t;

endpackage

// File: rtl/sram_strobe_fsm.sv
module sram_strobe_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int WE_CYC    = 2,
  parameter int HOLD_CYC  = 1,
  parameter int RD_CYC    = 2,
  parameter int TURN_CYC  = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    req,
  input  logic    wr,
  output strobe_t strb
);

  localparam int MAX_A = (SETUP_CYC > WE_CYC) ? SETUP_CYC : WE_CYC;
  localparam int MAX_B = (HOLD_CYC > RD_CYC) ? HOLD_CYC : RD_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC = (MAX_C > TURN_CYC) ? MAX_C : TURN_CYC;
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  ctrlState_e state;
  logic [CNT_W-1:0] cnt;
  logic lastCyc;

  assign lastCyc = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req) begin
          state <= wr ? ST_WSET : ST_RACT;
          cnt   <= wr ? CNT_W'(SETUP_CYC - 1) : CNT_W'(RD_CYC - 1);
        end
        ST_WSET: if (lastCyc) begin
          state <= ST_WPUL;
          cnt   <= CNT_W'(WE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        ST_WPUL: if (lastCyc) begin
          state <= ST_WHLD;
          cnt   <= CNT_W'(HOLD_CYC - 1);
        end else cnt <= cnt - 1'b1;
        ST_WHLD: if (lastCyc) state <= ST_IDLE;
                 else cnt <= cnt - 1'b1;
        ST_RACT: if (lastCyc) begin
          state <= ST_RTRN;
          cnt   <= CNT_W'(TURN_CYC - 1);
        end else cnt <= cnt - 1'b1;
        ST_RTRN: if (lastCyc) state <= ST_IDLE;
                 else cnt <= cnt - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb         = '{csN: 1'b1, weN: 1'b1, oeN: 1'b1, drive: 1'b0,
                     capture: 1'b0, accept: 1'b0, idle: 1'b0};
    unique case (state)
      ST_IDLE: begin
        strb.idle   = 1'b1;
        strb.accept = req;
      end
      ST_WSET, ST_WHLD: begin
        strb.csN   = 1'b0;
        strb.drive = 1'b1;
      end
      ST_WPUL: begin
        strb.csN   = 1'b0;
        strb.weN   = 1'b0;
        strb.drive = 1'b1;
      end
      ST_RACT: begin
        strb.csN     = 1'b0;
        strb.oeN     = 1'b0;
        strb.capture = lastCyc;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sram_strobe_dp.sv
module sram_strobe_dp
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic              memCsN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '0;
      memDqOut <= '0;
    end else if (strb.accept) begin
      memAddr  <= addr;
      memDqOut <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.capture;
      if (strb.capture) rdData <= memDqIn;
    end
  end

  assign memCsN  = strb.csN;
  assign memWeN  = strb.weN;
  assign memOeN  = strb.oeN;
  assign memDqOe = strb.drive;

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 1,
  parameter int WE_CYC    = 2,
  parameter int HOLD_CYC  = 1,
  parameter int RD_CYC    = 2,
  parameter int TURN_CYC  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  strobe_t strb;

  sram_strobe_fsm #(
    .SETUP_CYC(SETUP_CYC), .WE_CYC(WE_CYC), .HOLD_CYC(HOLD_CYC),
    .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC)
  ) fsm_i (
    .clk(clk), .rstN(rstN), .req(req), .wr(wr), .strb(strb)
  );

  sram_strobe_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .wdata(wdata),
    .memDqIn(memDqIn), .memAddr(memAddr), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memCsN(memCsN), .memWeN(memWeN), .memOeN(memOeN),
    .rdData(rdData), .rdValid(rdValid)
  );

  assign ready = strb.idle;

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int ADDR_W   = 19,
  parameter int TURN_CYC = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              ready,
  input logic              rdValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCsN,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memDqOe
);

  localparam int HC_W = $clog2(TURN_CYC + 1) + 1;
  logic [HC_W-1:0] oeHighCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) oeHighCnt <= HC_W'(TURN_CYC);
    else if (!memOeN) oeHighCnt <= '0;
    else if (oeHighCnt < HC_W'(TURN_CYC)) oeHighCnt <= oeHighCnt + 1'b1;
  end

  AST_WE_UNDER_CS: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (!memCsN && memOeN && memDqOe)); // R1

  AST_CS_LEADS_WE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memCsN) |-> memWeN); // R2

  AST_WE_RISE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (!memCsN && memDqOe)); // R2

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && $past(!memCsN)) |-> $stable(memAddr)); // R2

  AST_READ_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memWeN && !memCsN)); // R3

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (memOeN && oeHighCnt >= HC_W'(TURN_CYC))); // R4

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (memCsN && !memDqOe)); // R6

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(
  .ADDR_W(ADDR_W), .TURN_CYC(TURN_CYC)
) chk_i (
  .clk(clk), .rstN(rstN), .ready(ready), .rdValid(rdValid),
  .memAddr(memAddr), .memCsN(memCsN), .memWeN(memWeN), .memOeN(memOeN),
  .memDqOe(memDqOe)
);

// File: tb/sram_strobe_ctrl_tb.sv
module sram_strobe_ctrl_tb_top;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam int PER_NS = 8;
  localparam int S = 1, W = 2, H = 1, R = 3, T = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ready, rdValid, memCsN, memWeN, memOeN, memDqOe;
  logic [DW-1:0] rdData, memDqOut, memDqIn;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] mem [256];

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int oeHigh = T;

  always #4 clk = ~clk;

  sram_strobe_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(S), .WE_CYC(W), .HOLD_CYC(H),
    .RD_CYC(R), .TURN_CYC(T)
  ) dut_i (
    .clk(clk), .rstN(rstN), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .ready(ready), .rdData(rdData), .rdValid(rdValid), .memAddr(memAddr),
    .memCsN(memCsN), .memWeN(memWeN), .memOeN(memOeN), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // memory model: write taken at the rising write-enable edge
  always @(posedge memWeN)
    if (memCsN === 1'b0 && memDqOe === 1'b1) mem[memAddr] <= memDqOut;
  assign memDqIn = (!memCsN && !memOeN && memWeN) ? mem[memAddr] : 8'h00;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // bus contention watch, R4
  always @(negedge clk) if (rstN) begin
    if (memDqOe) chk(memOeN && oeHigh > T, "R4 drive during output window",
                     {memOeN, 8'(oeHigh)}, {1'b1, 8'(T + 1)});
    if (!memOeN) oeHigh = 0; else if (oeHigh <= T) oeHigh++;
  end

  function automatic logic [5:0] vec();
    return {memCsN, memWeN, memOeN, memDqOe, ready, rdValid};
  endfunction

  // caller is at a negedge with ready high; returns at one
  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit intrude);
    logic [5:0] e;
    req = 1; wr = 1; addr = a; wdata = d;
    for (int i = 1; i <= S + W + H + 1; i++) begin
      @(negedge clk);
      req = 0;
      if (i <= S)             e = 6'b011100;
      else if (i <= S + W)    e = 6'b001100;
      else if (i <= S + W + H) e = 6'b011100;
      else                    e = 6'b111010;
      chk(vec() == e, (i <= S) ? "R2 setup phase" : (i <= S + W) ? "R1 strobe pulse"
          : (i <= S + W + H) ? "R2 hold phase" : "R4 release after hold", vec(), e);
      if (i <= S + W + H) begin
        chk(memAddr == a && memDqOut == d, "R2 addr/data held",
            {memAddr, memDqOut}, {a, d});
        chk(!ready, "R6 ready low while busy", ready, 0);
      end
      if (intrude && i == 1) begin
        req = 1; wr = 1; addr = a ^ 8'h01; wdata = ~d;
      end
    end
  endtask

  task automatic doRead(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    logic [5:0] e;
    req = 1; wr = 0; addr = a;
    for (int i = 1; i <= R + T + 1; i++) begin
      @(negedge clk);
      req = 0;
      if (i <= R)          e = 6'b010000;
      else if (i == R + 1) e = 6'b111001;
      else if (i <= R + T) e = 6'b111000;
      else                 e = 6'b111010;
      chk(vec() == e, (i <= R) ? "R3 read window" : "R5 valid/turnaround", vec(), e);
      if (i <= R) chk(memAddr == a, "R3 read addr", memAddr, a);
      if (i == R + 1) chk(rdData == exp, "R8 read data", rdData, exp);
      if (i == R + T) chk(rdData == exp, "R5 rdData held", rdData, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'((a * 37 + 11 + k * 91) ^ (a >> 3));
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R7 reset state (still in reset)
    chk(vec() == 6'b111010, "R7 reset state", vec(), 6'b111010);
    rstN = 1;
    @(negedge clk);
    chk(vec() == 6'b111010, "R7 after release", vec(), 6'b111010);
    // nanosecond minimums against the configured cycle counts, R1 R2 R3 R4
    chk(W * PER_NS >= 15, "R1 pulse width ns", W * PER_NS, 15);
    chk(S * PER_NS >= 5, "R2 addr setup ns", S * PER_NS, 5);
    chk(H * PER_NS >= 3, "R2 hold ns", H * PER_NS, 3);
    chk((S + W) * PER_NS >= 12, "R2 data setup ns", (S + W) * PER_NS, 12);
    chk((S + W + H) * PER_NS >= 20, "R1 write cycle ns", (S + W + H) * PER_NS, 20);
    chk(R * PER_NS >= 20, "R3 read window ns", R * PER_NS, 20);
    chk(T * PER_NS >= 10, "R4 float time ns", T * PER_NS, 10);
    // full sweep: write every address, then read every address
    for (int a = 0; a < 256; a++) doWrite(AW'(a), pat(a, 0), 1'b0);
    for (int a = 0; a < 256; a++) doRead(AW'(a), pat(a, 0));
    // back-to-back write/read/write turnarounds with new patterns, R8
    for (int a = 0; a < 256; a++) begin
      doWrite(AW'(a), pat(a, 1), 1'b0);
      doRead(AW'(a), pat(a, 1));
    end
    // request while busy is dropped, R6
    doWrite(8'h40, 8'hA5, 1'b1);
    doRead(8'h41, pat(8'h41, 1));
    doRead(8'h40, 8'hA5);
    // idle with no request: strobes stay quiet, R6
    repeat (3) @(negedge clk);
    chk(vec() == 6'b111010, "R6 idle quiet", vec(), 6'b111010);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule